// File: doc/BRIEF.md
# Privilege-Aware Interrupt Pending Selector

This block keeps a pending vector and an enable vector for nine interrupt sources. There are three kinds of source: software, timer and external. Each kind exists at the user, supervisor and machine levels.

A global mask is formed from three side inputs:
- the hart's current privilege mode;
- the two delegation vectors (one set up by machine software, one by supervisor software);
- the user, supervisor and machine interrupt-enable status bits.

A source qualifies when it is pending, enabled and unmasked. The block registers a request flag and the cause id of the most urgent qualifying source. Trap-entry logic consumes these outputs.

Software changes the pending bits in four ways: it can post or clear a single source, clear everything, or overwrite the whole vector. The enable vector is written whole. Both vectors can be read back at any time.

Top module: `irq_pend_sel`

## Requirements
- R1: A synchronous active-high reset zeroes the pending vector, the enable vector, the request flag, the valid flag and the cause id.
- R2: Both vectors are 12 bits wide. User, supervisor and machine software sit at bits 0, 1 and 3. User, supervisor and machine timer sit at bits 4, 5 and 7. User, supervisor and machine external sit at bits 8, 9 and 11. Bits 2, 6 and 10 always read zero, and writes or posts aimed at them have no effect.
- R3: A pending-vector write or an enable-vector write replaces the whole vector, subject only to R2. The new value reads back after one clock edge.
- R4: A post for source n sets pending bit n, and a clear for n resets it. The clear-all strobe zeroes the pending vector. In the same cycle, a post wins over a clear or a clear-all, and a clear or a clear-all wins over a pending-vector write.
- R5: Privilege encoding 0 is user mode. In user mode:
  - each supervisor-level and machine-level source is unmasked if its supervisor-delegation bit is 0, or if the user enable status bit is 1;
  - user-level sources are unmasked exactly when the user enable status bit is 1.
- R6: Privilege encoding 1 is supervisor mode. In supervisor mode:
  - each machine-level source is unmasked if its machine-delegation bit is 0, or if the supervisor enable status bit is 1;
  - supervisor-level sources are unmasked exactly when the supervisor enable status bit is 1;
  - user-level sources are always masked.
- R7: Privilege encoding 3 is machine mode. In machine mode, machine-level sources are unmasked exactly when the machine enable status bit is 1, and every other source is masked.
- R8: Privilege encoding 2 is reserved and masks every source, so no request is raised.
- R9: The request flag is the registered OR of pending AND enable AND mask. It reflects the state and side inputs present before the clock edge, and the valid flag always equals it.
- R10: When several sources qualify, the cause id names the first in this order: machine external, machine software, machine timer, supervisor external, supervisor software, supervisor timer, user external, user software, user timer. The id is zero when nothing qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | 1 | Post strobe |
| post_idx | input | 4 | Cause number to post |
| clr_vld | input | 1 | Clear strobe |
| clr_idx | input | 4 | Cause number to clear |
| clr_all | input | 1 | Zero the whole pending vector |
| ip_wr_en | input | 1 | Pending-vector write strobe |
| ip_wr_data | input | 12 | Pending-vector write value |
| ie_wr_en | input | 1 | Enable-vector write strobe |
| ie_wr_data | input | 12 | Enable-vector write value |
| ip_rd | output | 12 | Pending vector readback |
| ie_rd | output | 12 | Enable vector readback |
| priv | input | 2 | Current privilege mode |
| mdeleg | input | 12 | Machine-to-supervisor delegation vector |
| sdeleg | input | 12 | Supervisor-to-user delegation vector |
| st_uie | input | 1 | User interrupt-enable status bit |
| st_sie | input | 1 | Supervisor interrupt-enable status bit |
| st_mie | input | 1 | Machine interrupt-enable status bit |
| irq_req | output | 1 | Registered request |
| irq_vld | output | 1 | Valid flag for irq_id |
| irq_id | output | 4 | Cause id of the chosen source |

## Verification
The bench builds the block with its default widths: a 12-bit cause vector and a 4-bit id. At these widths the mask space is small enough to sweep in full. The sweep covers all four privilege encodings and all eight status-bit combinations, crossed with three delegation patterns and each of the nine single-source pending patterns. This reaches every cell of the mask table, including the reserved mode. A second pass uses multi-bit pending patterns to test the selection order against an arithmetic urgency score. Strobe tests cover the same-cycle collisions between post, clear, clear-all and whole-vector write.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CAUSE_W = 12;
  localparam int ID_W    = 4;
  localparam int NSRC    = 9;
  localparam logic [CAUSE_W-1:0] LIVE_BITS = 12'hBBB;

  typedef enum logic [1:0] {
    PRV_USER = 2'd0,
    PRV_SUPV = 2'd1,
    PRV_RSVD = 2'd2,
    PRV_MACH = 2'd3
  } prv_e;

  // rank 0 is most urgent
  function automatic logic [ID_W-1:0] rank_to_cause(input int rank);
    case (rank)
      0:       return 4'd11;
      1:       return 4'd3;
      2:       return 4'd7;
      3:       return 4'd9;
      4:       return 4'd1;
      5:       return 4'd5;
      6:       return 4'd8;
      7:       return 4'd0;
      default: return 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/irq_mask_gen.sv
module irq_mask_gen
  import irq_pkg::*;
#(
  parameter int W = CAUSE_W
) (
  input  logic [1:0]   priv,
  input  logic [W-1:0] mdeleg,
  input  logic [W-1:0] sdeleg,
  input  logic         st_uie,
  input  logic         st_sie,
  input  logic         st_mie,
  output logic [W-1:0] gmask
);
  // level of a cause = low two bits: 0 user, 1 supervisor, 3 machine
  always_comb begin
    gmask = '0;
    for (int b = 0; b < W; b++) begin
      case (prv_e'(priv))
        PRV_USER: begin
          if (b % 4 == 0)      gmask[b] = st_uie;
          else if (b % 4 != 2) gmask[b] = !sdeleg[b] || st_uie;
        end
        PRV_SUPV: begin
          if (b % 4 == 1)      gmask[b] = st_sie;
          else if (b % 4 == 3) gmask[b] = !mdeleg[b] || st_sie;
        end
        PRV_MACH: begin
          if (b % 4 == 3)      gmask[b] = st_mie;
        end
        default: gmask[b] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/irq_pend_regs.sv
module irq_pend_regs
  import irq_pkg::*;
#(
  parameter int W   = CAUSE_W,
  parameter int IDW = ID_W,
  parameter logic [W-1:0] LIVE = LIVE_BITS
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           post_vld,
  input  logic [IDW-1:0] post_idx,
  input  logic           clr_vld,
  input  logic [IDW-1:0] clr_idx,
  input  logic           clr_all,
  input  logic           ip_wr_en,
  input  logic [W-1:0]   ip_wr_data,
  input  logic           ie_wr_en,
  input  logic [W-1:0]   ie_wr_data,
  output logic [W-1:0]   ip_q,
  output logic [W-1:0]   ie_q
);
  logic [W-1:0] ip_nxt;
  logic [W-1:0] post_oh, clr_oh;

  always_comb begin
    post_oh = '0;
    clr_oh  = '0;
    for (int b = 0; b < W; b++) begin
      post_oh[b] = post_vld && (post_idx == IDW'(b));
      clr_oh[b]  = clr_vld  && (clr_idx  == IDW'(b));
    end
  end

  always_comb begin
    ip_nxt = ip_wr_en ? ip_wr_data : ip_q;
    if (clr_all) ip_nxt = '0;
    ip_nxt = (ip_nxt & ~clr_oh) | post_oh;
    ip_nxt = ip_nxt & LIVE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ip_q <= '0;
      ie_q <= '0;
    end else begin
      ip_q <= ip_nxt;
      if (ie_wr_en) ie_q <= ie_wr_data & LIVE;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_pkg::*;
#(
  parameter int W   = CAUSE_W,
  parameter int IDW = ID_W,
  parameter int NS  = NSRC
) (
  input  logic [W-1:0]   qual,
  output logic           found,
  output logic [IDW-1:0] id
);
  logic [NS:0]    hit_chain;
  logic [IDW-1:0] id_chain [NS+1];

  assign hit_chain[NS] = 1'b0;
  assign id_chain[NS]  = '0;

  // walk from least to most urgent so the most urgent hit lands last
  for (genvar r = NS - 1; r >= 0; r--) begin : g_rank
    localparam logic [IDW-1:0] CID = rank_to_cause(r);
    assign hit_chain[r] = qual[CID] | hit_chain[r+1];
    assign id_chain[r]  = qual[CID] ? CID : id_chain[r+1];
  end

  assign found = hit_chain[0];
  assign id    = id_chain[0];
endmodule

// File: rtl/irq_pend_sel.sv
module irq_pend_sel
  import irq_pkg::*;
#(
  parameter int W   = CAUSE_W,
  parameter int IDW = ID_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           post_vld,
  input  logic [IDW-1:0] post_idx,
  input  logic           clr_vld,
  input  logic [IDW-1:0] clr_idx,
  input  logic           clr_all,
  input  logic           ip_wr_en,
  input  logic [W-1:0]   ip_wr_data,
  input  logic           ie_wr_en,
  input  logic [W-1:0]   ie_wr_data,
  output logic [W-1:0]   ip_rd,
  output logic [W-1:0]   ie_rd,
  input  logic [1:0]     priv,
  input  logic [W-1:0]   mdeleg,
  input  logic [W-1:0]   sdeleg,
  input  logic           st_uie,
  input  logic           st_sie,
  input  logic           st_mie,
  output logic           irq_req,
  output logic           irq_vld,
  output logic [IDW-1:0] irq_id
);
  logic [W-1:0]   ip_q, ie_q, gmask;
  logic           pick_hit;
  logic [IDW-1:0] pick_id;

  irq_pend_regs #(.W(W), .IDW(IDW)) regs_i (
    .clk(clk), .rst(rst),
    .post_vld(post_vld), .post_idx(post_idx),
    .clr_vld(clr_vld), .clr_idx(clr_idx), .clr_all(clr_all),
    .ip_wr_en(ip_wr_en), .ip_wr_data(ip_wr_data),
    .ie_wr_en(ie_wr_en), .ie_wr_data(ie_wr_data),
    .ip_q(ip_q), .ie_q(ie_q)
  );

  irq_mask_gen #(.W(W)) mask_i (
    .priv(priv), .mdeleg(mdeleg), .sdeleg(sdeleg),
    .st_uie(st_uie), .st_sie(st_sie), .st_mie(st_mie),
    .gmask(gmask)
  );

  irq_prio_pick #(.W(W), .IDW(IDW)) pick_i (
    .qual(ip_q & ie_q & gmask),
    .found(pick_hit),
    .id(pick_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vld <= 1'b0;
      irq_id  <= '0;
    end else begin
      irq_req <= pick_hit;
      irq_vld <= pick_hit;
      irq_id  <= pick_id;
    end
  end

  assign ip_rd = ip_q;
  assign ie_rd = ie_q;
endmodule

// File: rtl/irq_pend_sel_chk.sv
module irq_pend_sel_chk (
  input logic        clk,
  input logic        rst,
  input logic        post_vld,
  input logic [3:0]  post_idx,
  input logic        clr_vld,
  input logic [3:0]  clr_idx,
  input logic        clr_all,
  input logic [11:0] ip_rd,
  input logic [11:0] ie_rd,
  input logic [1:0]  priv,
  input logic        st_mie,
  input logic        irq_req,
  input logic        irq_vld,
  input logic [3:0]  irq_id
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $fell(rst) |-> (ip_rd == '0 && ie_rd == '0 && !irq_req && irq_id == '0));

  // R2
  tied_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (ip_rd[2] | ip_rd[6] | ip_rd[10] | ie_rd[2] | ie_rd[6] | ie_rd[10]) == 1'b0);

  // R4
  post_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (post_vld && post_idx < 4'd12 && post_idx[1:0] != 2'd2) |=> ip_rd[$past(post_idx)]);

  // R4
  clear_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_vld && clr_idx < 4'd12 && !(post_vld && post_idx == clr_idx))
      |=> !ip_rd[$past(clr_idx)]);

  // R4
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_all && !post_vld) |=> ip_rd == '0);

  // R8
  resv_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (priv == 2'd2) |=> !irq_req);

  // R7
  mach_off_chk: assert property (@(posedge clk) disable iff (rst)
    (priv == 2'd3 && !st_mie) |=> !irq_req);

  // R9
  vld_req_chk: assert property (@(posedge clk) disable iff (rst)
    irq_vld == irq_req);

  // R10
  live_id_chk: assert property (@(posedge clk) disable iff (rst)
    irq_vld |-> (irq_id < 4'd12 && irq_id[1:0] != 2'd2));
endmodule

bind irq_pend_sel irq_pend_sel_chk chk_i (
  .clk(clk), .rst(rst), .post_vld(post_vld), .post_idx(post_idx),
  .clr_vld(clr_vld), .clr_idx(clr_idx), .clr_all(clr_all),
  .ip_rd(ip_rd), .ie_rd(ie_rd), .priv(priv), .st_mie(st_mie),
  .irq_req(irq_req), .irq_vld(irq_vld), .irq_id(irq_id)
);

// File: tb/irq_pend_sel_tb.sv
module irq_pend_sel_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        post_vld = 0, clr_vld = 0, clr_all = 0, ip_wr_en = 0, ie_wr_en = 0;
  logic [3:0]  post_idx = 0, clr_idx = 0;
  logic [11:0] ip_wr_data = 0, ie_wr_data = 0, mdeleg = 0, sdeleg = 0;
  logic [11:0] ip_rd, ie_rd;
  logic [1:0]  priv = 0;
  logic        st_uie = 0, st_sie = 0, st_mie = 0;
  logic        irq_req, irq_vld;
  logic [3:0]  irq_id;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pend_sel dut_i (
    .clk(clk), .rst(rst),
    .post_vld(post_vld), .post_idx(post_idx),
    .clr_vld(clr_vld), .clr_idx(clr_idx), .clr_all(clr_all),
    .ip_wr_en(ip_wr_en), .ip_wr_data(ip_wr_data),
    .ie_wr_en(ie_wr_en), .ie_wr_data(ie_wr_data),
    .ip_rd(ip_rd), .ie_rd(ie_rd),
    .priv(priv), .mdeleg(mdeleg), .sdeleg(sdeleg),
    .st_uie(st_uie), .st_sie(st_sie), .st_mie(st_mie),
    .irq_req(irq_req), .irq_vld(irq_vld), .irq_id(irq_id)
  );

  task automatic check(input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // expected mask bit from the requirement text
  function automatic logic mask_bit(input int b, input logic [1:0] p, input logic [2:0] st,
                                    input logic [11:0] md, input logic [11:0] sd);
    int lvl = b % 4;
    logic u = st[0], s = st[1], m = st[2];
    if (lvl == 2) return 1'b0;
    case (p)
      2'd0: return (lvl == 0) ? u : (!sd[b] || u);
      2'd1: return (lvl == 0) ? 1'b0 : (lvl == 1) ? s : (!md[b] || s);
      2'd3: return (lvl == 3) ? m : 1'b0;
      default: return 1'b0;
    endcase
  endfunction

  // urgency: level first, then external > software > timer
  function automatic int score(input int b);
    int lvl = b % 4;
    int kind = (b >= 8) ? 2 : (b < 4) ? 1 : 0;
    return lvl * 3 + kind;
  endfunction

  task automatic vec(input string rq, input logic [1:0] p, input logic [2:0] st,
                     input logic [11:0] md, input logic [11:0] sd,
                     input logic [11:0] ipv, input logic [11:0] iev);
    logic exp_req = 1'b0;
    int   best = -1;
    logic [3:0] exp_id = 4'd0;
    @(negedge clk);
    priv = p; {st_mie, st_sie, st_uie} = st; mdeleg = md; sdeleg = sd;
    ip_wr_en = 1; ip_wr_data = ipv; ie_wr_en = 1; ie_wr_data = iev;
    @(negedge clk);
    ip_wr_en = 0; ie_wr_en = 0;
    @(negedge clk);
    for (int b = 0; b < 12; b++) begin
      if (ipv[b] && iev[b] && b % 4 != 2 && mask_bit(b, p, st, md, sd)) begin
        exp_req = 1'b1;
        if (score(b) > best) begin best = score(b); exp_id = 4'(b); end
      end
    end
    check(rq, {10'd0, irq_req, irq_vld, irq_id}, {10'd0, exp_req, exp_req, exp_id});
  endtask

  initial begin
    logic [11:0] dl [3];
    dl[0] = 12'h000; dl[1] = 12'hFFF; dl[2] = 12'hA5A;

    // R1 reset state
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1", {4'd0, ip_rd}, 16'd0);
    check("R1", {4'd0, ie_rd}, 16'd0);
    check("R1", {13'd0, irq_req, irq_vld, 1'b0}, 16'd0);

    // R2 R3 whole writes and tied bits
    @(negedge clk); ip_wr_en = 1; ip_wr_data = 12'hFFF; ie_wr_en = 1; ie_wr_data = 12'h5A5;
    @(negedge clk); ip_wr_en = 0; ie_wr_en = 0;
    check("R2", {4'd0, ip_rd}, 16'h0BBB);
    check("R3", {4'd0, ie_rd}, 16'h01A1);
    @(negedge clk); ip_wr_en = 1; ip_wr_data = 12'h123;
    @(negedge clk); ip_wr_en = 0;
    check("R3", {4'd0, ip_rd}, 16'h0123 & 16'h0BBB);

    // R4 strobes
    @(negedge clk); clr_all = 1;
    @(negedge clk); clr_all = 0;
    check("R4 clear-all", {4'd0, ip_rd}, 16'd0);
    @(negedge clk); post_vld = 1; post_idx = 5;
    @(negedge clk); post_vld = 0;
    check("R4 post", {4'd0, ip_rd}, 16'h0020);
    @(negedge clk); post_vld = 1; post_idx = 5; clr_vld = 1; clr_idx = 5;
    @(negedge clk); post_vld = 0; clr_vld = 0;
    check("R4 post beats clear", {4'd0, ip_rd}, 16'h0020);
    @(negedge clk); clr_vld = 1; clr_idx = 5;
    @(negedge clk); clr_vld = 0;
    check("R4 clear", {4'd0, ip_rd}, 16'h0000);
    @(negedge clk); ip_wr_en = 1; ip_wr_data = 12'h0B0; clr_all = 1; post_vld = 1; post_idx = 11;
    @(negedge clk); ip_wr_en = 0; clr_all = 0; post_vld = 0;
    check("R4 post beats clear-all and write", {4'd0, ip_rd}, 16'h0800);
    @(negedge clk); ip_wr_en = 1; ip_wr_data = 12'h003; clr_vld = 1; clr_idx = 0;
    @(negedge clk); ip_wr_en = 0; clr_vld = 0;
    check("R4 clear beats write", {4'd0, ip_rd}, 16'h0002);
    @(negedge clk); post_vld = 1; post_idx = 6;
    @(negedge clk); post_vld = 0;
    check("R2 post to tied bit", {4'd0, ip_rd}, 16'h0002);

    // R5 R6 R7 R8 R9 single-source sweep over all modes and status bits
    for (int p = 0; p < 4; p++)
      for (int st = 0; st < 8; st++)
        for (int d = 0; d < 3; d++)
          for (int b = 0; b < 12; b++)
            if (b % 4 != 2)
              vec(p == 0 ? "R5" : p == 1 ? "R6" : p == 2 ? "R8" : "R7",
                  2'(p), 3'(st), dl[d], ~dl[d], 12'(1 << b), 12'hFFF);

    // R9 enable gating
    vec("R9 enable gate", 2'd3, 3'b111, 12'h000, 12'h000, 12'h888, 12'h000);
    vec("R9 enable gate", 2'd3, 3'b111, 12'h000, 12'h000, 12'h888, 12'h080);

    // R10 multi-source priority
    for (int k = 0; k < 120; k++)
      vec("R10", 2'(k % 4), 3'(k / 4), dl[k % 3], dl[(k + 1) % 3],
          12'((k * 12'h2F7 + 12'h13D) ^ (k << 5)), 12'hFFF);
    for (int p = 0; p < 4; p++)
      vec("R10 all pending", 2'(p), 3'b111, 12'h000, 12'h000, 12'hBBB, 12'hBBB);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule